// File: doc/BRIEF.md
# Speculative Line Tracker with Commit Snoop

This block holds the tag-side state of a small direct-mapped cache used by a node that runs transactions speculatively. For each line it keeps a valid bit, a tag, a speculative-read flag and a speculative-write flag. Local loads and stores mark the line they touch. The block also watches commit packets that other nodes broadcast. When a packet names an address that the running transaction has read, the transaction has consumed stale data. The block then raises a one-cycle violation pulse and, in the same edge, drops every speculatively written line and wipes all speculative flags.

A commit packet either carries data or carries only an address. An address-only packet removes the matching line. A packet with data leaves the line in place and emits an update strobe with the line index, so that the data array can take the new value. Packets that carry this node's own identifier are ignored. After a violation the block holds a pending flag until the processor acknowledges the restart. While that flag is set, further hits and local accesses have no effect on the speculative state.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid with both speculative flags clear, and `violation`, `viol_pending` and `upd_valid` are low.
- R2: A load (`acc_valid` high, `acc_is_store` 0) to an index whose valid line holds the same tag sets that line's read flag. The address is split as low `IDX_W` bits = index and upper bits = tag. The line's other flags are unchanged.
- R3: A store (`acc_is_store` 1) sets the line's modified flag and leaves the line valid.
- R4: A foreign snoop whose index and tag match a valid line with its read flag set drives `violation` high on the next clock edge, for exactly one cycle.
- R5: In the cycle a violation is taken, every line with its modified flag set becomes invalid, all read and modified flags clear, and any local access in that cycle is dropped.
- R6: A foreign address-only snoop (`snp_has_data` 0) that hits a line clears that line's valid, read and modified flags. A snoop whose tag differs, or whose index is invalid, changes nothing.
- R7: A foreign snoop with data (`snp_has_data` 1) that hits a line keeps the line valid. On the next edge it pulses `upd_valid` for one cycle, with `upd_index` set to the line index.
- R8: `commit_i` clears all read and modified flags on the next edge and keeps valid lines valid. A local access in the same cycle is applied after the clear.
- R9: A snoop hit on a line whose modified flag is set but whose read flag is clear raises no violation.
- R10: Once a violation fires, `viol_pending` stays high until `restart_ack`. While it is high, snoop hits raise no violation and local loads and stores change no flag.
- R11: A snoop whose `snp_node` equals `MY_NODE` is ignored: no violation, no invalidation and no update strobe.
- R12: A local access to an index that is invalid or holds another tag installs the new tag and marks the line valid. Its flags restart from that access alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local load or store this cycle |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Local line address {tag, index} |
| commit_i | input | 1 | Local transaction committed |
| snp_valid | input | 1 | Snooped commit packet entry present |
| snp_node | input | NODE_W | Identifier of the committing node |
| snp_addr | input | ADDR_W | Snooped line address {tag, index} |
| snp_has_data | input | 1 | Packet carries data (update) instead of address only (invalidate) |
| restart_ack | input | 1 | Processor has restarted the violated transaction |
| violation | output | 1 | One-cycle violation pulse |
| viol_pending | output | 1 | Violation waiting for restart acknowledge |
| upd_valid | output | 1 | One-cycle update strobe for the data array |
| upd_index | output | IDX_W | Line index to update |
| line_valid | output | NUM_LINES | Valid flag per line |
| line_read | output | NUM_LINES | Speculative read flag per line |
| line_mod | output | NUM_LINES | Speculative modified flag per line |

## Verification
The bench targets hits on lines that are only modified. A design that keyed the violation on any speculative flag would fire there. It also targets snoops that match the index but carry another tag, which a design comparing only the index would wrongly invalidate. Packets from the node itself and hits that arrive while a violation is pending are both driven. Either would produce extra violation pulses or a pulse longer than one cycle in a faulty design. Accesses that coincide with a violation or a commit are checked too: a wrong ordering would leave stale flags set, or would lose the new transaction's first access.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/spec_trk_snoop.sv
module spec_trk_snoop #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 6,
    parameter int NODE_W    = 2,
    parameter int MY_NODE   = 1
) (
    input  logic                                snp_valid,
    input  logic [NODE_W-1:0]                   snp_node,
    input  logic [IDX_W+TAG_W-1:0]              snp_addr,
    input  logic [NUM_LINES-1:0]                valid_vec,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]     tag_vec,
    output logic                                foreign,
    output logic [NUM_LINES-1:0]                hit_vec
);
    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;

    assign s_idx   = snp_addr[IDX_W-1:0];
    assign s_tag   = snp_addr[IDX_W+TAG_W-1:IDX_W];
    assign foreign = snp_valid && (snp_node != NODE_W'(MY_NODE));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
        assign hit_vec[i] = foreign && valid_vec[i] &&
                            (s_idx == IDX_W'(i)) && (tag_vec[i] == s_tag);
    end
endmodule

// File: rtl/spec_trk_line.sv
module spec_trk_line
    import spec_trk_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_hit,
    input  logic             snp_has_data,
    input  logic             flash,
    input  logic             commit,
    input  logic             acc_sel,
    input  acc_kind_e        acc_kind,
    input  logic [TAG_W-1:0] acc_tag,
    output logic             valid_o,
    output logic             rd_o,
    output logic             mod_o,
    output logic [TAG_W-1:0] tag_o
);
    typedef struct packed {
        logic             valid;
        logic             rd;
        logic             mod;
        logic [TAG_W-1:0] tag;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (snp_hit && !snp_has_data) begin
            line_d.valid = 1'b0;
            line_d.rd    = 1'b0;
            line_d.mod   = 1'b0;
        end
        if (flash) begin
            if (line_q.mod) line_d.valid = 1'b0;
            line_d.rd  = 1'b0;
            line_d.mod = 1'b0;
        end else if (commit) begin
            line_d.rd  = 1'b0;
            line_d.mod = 1'b0;
        end
        if (acc_sel) begin
            if (!line_d.valid || (line_d.tag != acc_tag)) begin
                line_d.tag   = acc_tag;
                line_d.valid = 1'b1;
                line_d.rd    = 1'b0;
                line_d.mod   = 1'b0;
            end
            if (acc_kind == ACC_STORE) line_d.mod = 1'b1;
            else                       line_d.rd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign valid_o = line_q.valid;
    assign rd_o    = line_q.rd;
    assign mod_o   = line_q.mod;
    assign tag_o   = line_q.tag;

    // R3: a speculatively written line is always resident
    p_mod_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_q.mod |-> line_q.valid);

    // R6: address-only hit with no refill removes the line
    p_inv_drops_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !snp_has_data && !acc_sel) |=> !line_q.valid);
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
    import spec_trk_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 6,
    parameter int NODE_W    = 2,
    parameter int MY_NODE   = 1,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = IDX_W + TAG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_is_store,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  commit_i,
    input  logic                  snp_valid,
    input  logic [NODE_W-1:0]     snp_node,
    input  logic [ADDR_W-1:0]     snp_addr,
    input  logic                  snp_has_data,
    input  logic                  restart_ack,
    output logic                  violation,
    output logic                  viol_pending,
    output logic                  upd_valid,
    output logic [IDX_W-1:0]      upd_index,
    output logic [NUM_LINES-1:0]  line_valid,
    output logic [NUM_LINES-1:0]  line_read,
    output logic [NUM_LINES-1:0]  line_mod
);
    typedef struct packed {
        logic             viol;
        logic             pend;
        logic             upd;
        logic [IDX_W-1:0] upd_idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_LINES-1:0][TAG_W-1:0] tag_vec;
    logic [NUM_LINES-1:0]            hit_vec;
    logic [NUM_LINES-1:0]            acc_sel;
    logic                            foreign;
    logic                            viol_now;
    logic [IDX_W-1:0]                a_idx;
    logic [TAG_W-1:0]                a_tag;

    assign a_idx = acc_addr[IDX_W-1:0];
    assign a_tag = acc_addr[ADDR_W-1:IDX_W];

    spec_trk_snoop #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .NODE_W    (NODE_W),
        .MY_NODE   (MY_NODE)
    ) u_snoop (
        .snp_valid (snp_valid),
        .snp_node  (snp_node),
        .snp_addr  (snp_addr),
        .valid_vec (line_valid),
        .tag_vec   (tag_vec),
        .foreign   (foreign),
        .hit_vec   (hit_vec)
    );

    assign viol_now = (|(hit_vec & line_read)) && !ctl_q.pend;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign acc_sel[i] = acc_valid && (a_idx == IDX_W'(i)) &&
                            !ctl_q.pend && !viol_now;
        spec_trk_line #(.TAG_W(TAG_W)) u_line (
            .clk          (clk),
            .rst_n        (rst_n),
            .snp_hit      (hit_vec[i]),
            .snp_has_data (snp_has_data),
            .flash        (viol_now),
            .commit       (commit_i),
            .acc_sel      (acc_sel[i]),
            .acc_kind     (acc_kind_e'(acc_is_store)),
            .acc_tag      (a_tag),
            .valid_o      (line_valid[i]),
            .rd_o         (line_read[i]),
            .mod_o        (line_mod[i]),
            .tag_o        (tag_vec[i])
        );
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.viol    = viol_now;
        ctl_d.upd     = snp_has_data && (|hit_vec);
        ctl_d.upd_idx = snp_addr[IDX_W-1:0];
        if (viol_now)         ctl_d.pend = 1'b1;
        else if (restart_ack) ctl_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign violation    = ctl_q.viol;
    assign viol_pending = ctl_q.pend;
    assign upd_valid    = ctl_q.upd;
    assign upd_index    = ctl_q.upd_idx;

    // R4: violation is a single-cycle pulse
    p_viol_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> !violation);

    // R5: the violation edge leaves no speculative flag behind
    p_flash_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (line_read == '0 && line_mod == '0));

    // R8: commit without a new access leaves no speculative flag
    p_commit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !acc_valid) |=> (line_read == '0 && line_mod == '0));

    // R10: no new violation while one is pending
    p_hold_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pending |=> !violation);

    // R10: a violation always leaves the pending flag set
    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> viol_pending);

    // R11: own packets never cause a violation or an update
    p_own_filtered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_node == NODE_W'(MY_NODE)) |=> (!violation && !upd_valid));
endmodule

// File: tb/sim_spec_line_tracker.sv
module sim_spec_line_tracker;
    localparam int N      = 8;
    localparam int TAG_W  = 6;
    localparam int NODE_W = 2;
    localparam int MY     = 1;
    localparam int IDX_W  = 3;
    localparam int ADDR_W = IDX_W + TAG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_is_store = 0, commit_i = 0;
    logic snp_valid = 0, snp_has_data = 0, restart_ack = 0;
    logic [ADDR_W-1:0] acc_addr = '0, snp_addr = '0;
    logic [NODE_W-1:0] snp_node = '0;
    logic violation, viol_pending, upd_valid;
    logic [IDX_W-1:0] upd_index;
    logic [N-1:0] line_valid, line_read, line_mod;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the line state
    logic [N-1:0] m_valid = '0, m_rd = '0, m_mod = '0;
    logic [TAG_W-1:0] m_tag [N];
    logic m_viol = 0, m_pend = 0, m_upd = 0;
    logic [IDX_W-1:0] m_upd_idx = '0;

    always #10 clk = ~clk;

    spec_line_tracker #(.NUM_LINES(N), .TAG_W(TAG_W), .NODE_W(NODE_W), .MY_NODE(MY)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
        .acc_addr(acc_addr), .commit_i(commit_i), .snp_valid(snp_valid),
        .snp_node(snp_node), .snp_addr(snp_addr), .snp_has_data(snp_has_data),
        .restart_ack(restart_ack), .violation(violation), .viol_pending(viol_pending),
        .upd_valid(upd_valid), .upd_index(upd_index), .line_valid(line_valid),
        .line_read(line_read), .line_mod(line_mod)
    );

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [IDX_W-1:0] si, ai;
        logic [TAG_W-1:0] st, at;
        logic foreign, hit, viol;
        si = snp_addr[IDX_W-1:0];  st = snp_addr[ADDR_W-1:IDX_W];
        ai = acc_addr[IDX_W-1:0];  at = acc_addr[ADDR_W-1:IDX_W];
        foreign = snp_valid && (snp_node != NODE_W'(MY));
        hit  = foreign && m_valid[si] && (m_tag[si] == st);
        viol = hit && m_rd[si] && !m_pend;
        if (hit && !snp_has_data) begin
            m_valid[si] = 0; m_rd[si] = 0; m_mod[si] = 0;
        end
        if (viol) begin
            m_valid = m_valid & ~m_mod; m_rd = '0; m_mod = '0;
        end else if (commit_i) begin
            m_rd = '0; m_mod = '0;
        end
        if (acc_valid && !m_pend && !viol) begin
            if (!m_valid[ai] || m_tag[ai] != at) begin
                m_tag[ai] = at; m_valid[ai] = 1; m_rd[ai] = 0; m_mod[ai] = 0;
            end
            if (acc_is_store) m_mod[ai] = 1; else m_rd[ai] = 1;
        end
        m_upd = hit && snp_has_data;
        m_upd_idx = si;
        if (viol) m_pend = 1; else if (restart_ack) m_pend = 0;
        m_viol = viol;
    endtask

    task automatic compare_all(input string rq);
        chk(rq, "violation", 32'(violation), 32'(m_viol));
        chk(rq, "pending", 32'(viol_pending), 32'(m_pend));
        chk(rq, "upd_valid", 32'(upd_valid), 32'(m_upd));
        if (m_upd) chk(rq, "upd_index", 32'(upd_index), 32'(m_upd_idx));
        chk(rq, "line_valid", 32'(line_valid), 32'(m_valid));
        chk(rq, "line_read", 32'(line_read), 32'(m_rd));
        chk(rq, "line_mod", 32'(line_mod), 32'(m_mod));
    endtask

    // drive at negedge, model, clock, compare at next negedge
    task automatic cyc(input logic av, input logic ast, input logic [ADDR_W-1:0] aa,
                       input logic cm, input logic sv, input int nd,
                       input logic [ADDR_W-1:0] sa, input logic sd, input logic ak,
                       input string rq);
        acc_valid = av; acc_is_store = ast; acc_addr = aa; commit_i = cm;
        snp_valid = sv; snp_node = NODE_W'(nd); snp_addr = sa; snp_has_data = sd;
        restart_ack = ak;
        model_step();
        @(negedge clk);
        compare_all(rq);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_tag[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
        // R2 / R3 basic marking, R12 install
        cyc(1, 0, mk(5, 1), 0, 0, 0, '0, 0, 0, "R2");
        cyc(1, 1, mk(5, 2), 0, 0, 0, '0, 0, 0, "R3");
        cyc(1, 0, mk(5, 2), 0, 0, 0, '0, 0, 0, "R2");
        cyc(1, 1, mk(7, 5), 0, 0, 0, '0, 0, 0, "R3");
        // R9 / R7: modified-only hit with data: update, no violation
        cyc(0, 0, '0, 0, 1, 0, mk(7, 5), 1, 0, "R9");
        chk("R7", "line5 kept", 32'(line_valid[5]), 32'd1);
        // R6: tag mismatch does nothing, then address-only hit drops line
        cyc(0, 0, '0, 0, 1, 3, mk(6, 1), 0, 0, "R6");
        cyc(0, 0, '0, 0, 1, 2, mk(7, 5), 0, 0, "R6");
        // R11: own packet on a read line
        cyc(0, 0, '0, 0, 1, MY, mk(5, 1), 0, 0, "R11");
        // R4 / R5: violation with a concurrent access being dropped
        cyc(1, 1, mk(5, 3), 0, 0, 0, '0, 0, 0, "R3");
        cyc(1, 1, mk(4, 6), 0, 1, 0, mk(5, 1), 0, 0, "R5");
        chk("R4", "violation high", 32'(violation), 32'd1);
        chk("R5", "line3 invalid", 32'(line_valid[3]), 32'd0);
        // R10: pending blocks accesses and hits
        cyc(1, 0, mk(4, 4), 0, 0, 0, '0, 0, 0, "R10");
        chk("R4", "pulse ended", 32'(violation), 32'd0);
        cyc(0, 0, '0, 0, 0, 0, '0, 0, 1, "R10");
        cyc(1, 0, mk(4, 4), 0, 0, 0, '0, 0, 0, "R10");
        cyc(1, 1, mk(4, 4), 0, 0, 0, '0, 0, 0, "R3");
        // R8: commit clears, same-cycle access lands afterwards
        cyc(1, 0, mk(5, 0), 1, 0, 0, '0, 0, 0, "R8");
        cyc(0, 0, '0, 1, 0, 0, '0, 0, 0, "R8");
        chk("R8", "line4 kept", 32'(line_valid[4]), 32'd1);
        // R12: replace tag at index 4, old tag no longer hits
        cyc(1, 0, mk(9, 4), 0, 0, 0, '0, 0, 0, "R12");
        cyc(0, 0, '0, 0, 1, 0, mk(4, 4), 0, 0, "R12");
        chk("R12", "line4 still valid", 32'(line_valid[4]), 32'd1);
        // constrained random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom % 3) != 0, $urandom % 2, mk($urandom % 3, $urandom % N),
                ($urandom % 12) == 0, ($urandom % 3) == 0, $urandom % 4,
                mk($urandom % 3, $urandom % N), $urandom % 2,
                ($urandom % 4) == 0, "R5 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule